// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a 16-bit virtual address into a physical address using a small on-chip table of segment descriptors. The top bits of the address pick a descriptor. The rest of the address is an offset into that segment. Each descriptor has four fields: a base, a limit, a present flag and a store-permission flag. The translated address is the base plus the offset.

Each access is checked before it is let through. An access to a segment that is not present, an offset at or beyond the limit, and a store into a segment without store permission each report their own fault code. A faulting access never carries a physical address.

A privileged loader fills the table through a one-cycle write port. Requests come in on a valid/ready port together with a read/write indication. Each response appears one clock after its request is accepted.

Top module: `seg_xlate`

## Requirements
- R1: `req_addr[15:14]` selects one of four descriptors, and `req_addr[13:0]` is the offset, zero-extended to 16 bits.
- R2: With no fault, `rsp_paddr` equals the selected base plus the offset, wrapping modulo 2^16.
- R3: An offset greater than or equal to the descriptor limit reports `rsp_fault` = 2'b10.
- R4: An access to a descriptor whose present flag is 0 reports `rsp_fault` = 2'b01.
- R5: A store (`req_write` = 1) to a descriptor whose store-permission flag is 0 reports `rsp_fault` = 2'b11. A load from such a descriptor does not fault.
- R6: When several faults apply, the reported code follows this priority: not present (01), then limit (10), then store permission (11). A fault-free access reports 2'b00.
- R7: A descriptor write takes effect at the clock edge that samples it. A request accepted at that same edge is translated with the old descriptor contents.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. Its response is valid in the following cycle. `req_ready` is high when no response is pending or `rsp_ready` is high. A pending response stays unchanged while `rsp_ready` is low.
- R9: Reset marks all four descriptors not present and clears `rsp_valid`.
- R10: Whenever `rsp_fault` is nonzero, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Descriptor index to write |
| cfg_base | input | 16 | Base to store |
| cfg_limit | input | 16 | Limit to store |
| cfg_present | input | 1 | Present flag to store |
| cfg_store_ok | input | 1 | Store-permission flag to store |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_paddr | output | 16 | Physical address (0 on fault) |
| rsp_fault | output | 2 | Fault code: 00 none, 01 not present, 10 limit, 11 store permission |

## Verification
The bench targets the following corner cases:
- **Offset one below the limit and exactly at the limit.** A design that compares with strict greater-than would let the first out-of-range byte through.
- **Sum past 0xFFFF.** Checks that the add wraps rather than saturating or faulting.
- **Faults in combination.** A non-present segment that is also over its limit and written, or a read-only segment that is over its limit and written. A wrong priority order shows up as the wrong code.
- **Descriptor write in the same cycle as a translation of that segment.** A forwarding design would return the new base too early.
- **Response held under backpressure.** Checks that the held response does not change while the consumer stalls.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_ABSENT  = 2'b01,
      FLT_RANGE   = 2'b10,
      FLT_NOSTORE = 2'b11
   } flt_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
   parameter int SEG_W  = 2,
   parameter int BASE_W = 16,
   parameter int LIM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEG_W-1:0]  wsel,
   input  logic [BASE_W-1:0] wbase,
   input  logic [LIM_W-1:0]  wlimit,
   input  logic              wpresent,
   input  logic              wstore_ok,
   input  logic [SEG_W-1:0]  rsel,
   output logic [BASE_W-1:0] rbase,
   output logic [LIM_W-1:0]  rlimit,
   output logic              rpresent,
   output logic              rstore_ok
);
   localparam int NSEG = 1 << SEG_W;

   logic [BASE_W-1:0] base_a    [NSEG];
   logic [LIM_W-1:0]  limit_a   [NSEG];
   logic              present_a [NSEG];
   logic              stok_a    [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_ent
      logic [BASE_W-1:0] base_q;
      logic [LIM_W-1:0]  limit_q;
      logic              present_q;
      logic              stok_q;
      logic              hit;

      assign hit = we && (wsel == SEG_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q    <= '0;
            limit_q   <= '0;
            present_q <= 1'b0;
            stok_q    <= 1'b0;
         end else if (hit) begin
            base_q    <= wbase;
            limit_q   <= wlimit;
            present_q <= wpresent;
            stok_q    <= wstore_ok;
         end
      end

      assign base_a[g]    = base_q;
      assign limit_a[g]   = limit_q;
      assign present_a[g] = present_q;
      assign stok_a[g]    = stok_q;
   end

   assign rbase     = base_a[rsel];
   assign rlimit    = limit_a[rsel];
   assign rpresent  = present_a[rsel];
   assign rstore_ok = stok_a[rsel];
endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W = 14,
   parameter int PA_W  = 16,
   parameter int LIM_W = 16
) (
   input  logic [OFF_W-1:0] offset,
   input  logic [PA_W-1:0]  base,
   input  logic [LIM_W-1:0] limit,
   input  logic             present,
   input  logic             store_ok,
   input  logic             is_store,
   output logic [PA_W-1:0]  paddr,
   output flt_e             fault
);
   logic [PA_W-1:0]  off_pa;
   logic [LIM_W-1:0] off_lim;
   logic [PA_W-1:0]  sum;
   logic             over;

   assign off_pa  = PA_W'(offset);
   assign off_lim = LIM_W'(offset);
   assign sum     = base + off_pa;
   assign over    = (off_lim >= limit);

   always_comb begin
      if (!present)                   fault = FLT_ABSENT;
      else if (over)                  fault = FLT_RANGE;
      else if (is_store && !store_ok) fault = FLT_NOSTORE;
      else                            fault = FLT_NONE;
   end

   assign paddr = (fault == FLT_NONE) ? sum : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int VA_W  = 16,
   parameter int SEG_W = 2,
   parameter int PA_W  = 16,
   parameter int LIM_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEG_W-1:0]  cfg_sel,
   input  logic [PA_W-1:0]   cfg_base,
   input  logic [LIM_W-1:0]  cfg_limit,
   input  logic              cfg_present,
   input  logic              cfg_store_ok,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_addr,
   input  logic              req_write,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic [1:0]        rsp_fault
);
   localparam int OFF_W = VA_W - SEG_W;

   if (SEG_W < 1 || SEG_W >= VA_W) begin : g_bad_seg
      $error("seg_xlate: SEG_W must be in 1..VA_W-1");
   end
   if (PA_W < OFF_W || LIM_W < OFF_W) begin : g_bad_width
      $error("seg_xlate: PA_W and LIM_W must cover the offset");
   end

   logic [SEG_W-1:0] seg;
   logic [OFF_W-1:0] off;
   logic [PA_W-1:0]  d_base;
   logic [LIM_W-1:0] d_limit;
   logic             d_present;
   logic             d_stok;
   logic [PA_W-1:0]  x_paddr;
   flt_e             x_fault;
   logic             accept;
   logic             vld_q;
   logic [PA_W-1:0]  paddr_q;
   flt_e             fault_q;

   assign seg = req_addr[VA_W-1 -: SEG_W];
   assign off = req_addr[OFF_W-1:0];

   seg_desc_table #(.SEG_W(SEG_W), .BASE_W(PA_W), .LIM_W(LIM_W)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .wsel      (cfg_sel),
      .wbase     (cfg_base),
      .wlimit    (cfg_limit),
      .wpresent  (cfg_present),
      .wstore_ok (cfg_store_ok),
      .rsel      (seg),
      .rbase     (d_base),
      .rlimit    (d_limit),
      .rpresent  (d_present),
      .rstore_ok (d_stok)
   );

   seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_chk_logic (
      .offset   (off),
      .base     (d_base),
      .limit    (d_limit),
      .present  (d_present),
      .store_ok (d_stok),
      .is_store (req_write),
      .paddr    (x_paddr),
      .fault    (x_fault)
   );

   assign req_ready = !vld_q || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         paddr_q <= '0;
         fault_q <= FLT_NONE;
      end else begin
         vld_q <= accept || (vld_q && !rsp_ready);
         if (accept) begin
            paddr_q <= x_paddr;
            fault_q <= x_fault;
         end
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_paddr = paddr_q;
   assign rsp_fault = fault_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int VA_W = 16,
   parameter int PA_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_addr,
   input logic            req_write,
   input logic            rsp_valid,
   input logic            rsp_ready,
   input logic [PA_W-1:0] rsp_paddr,
   input logic [1:0]      rsp_fault
);
   // R8: a stalled response holds still
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

   // R8: an accepted request yields a response next cycle
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R8, R9: no response appears without an accepted request or a held one
   p_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(req_valid && req_ready) || $past(rsp_valid)));

   // R10: faulting responses carry no address
   p_nopa_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

   // R5: a load never reports a store-permission fault
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write) |=> (rsp_fault != 2'b11));

   // R8: ready is high whenever no response is pending
   p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);
endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_seg_xlate_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .req_write (req_write),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_paddr (rsp_paddr),
   .rsp_fault (rsp_fault)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_base = '0;
   logic [15:0] cfg_limit = '0;
   logic        cfg_present = 1'b0;
   logic        cfg_store_ok = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [15:0] rsp_paddr;
   logic [1:0]  rsp_fault;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] m_base [4];
   logic [15:0] m_lim  [4];
   logic        m_pres [4];
   logic        m_stok [4];

   always #5 clk = ~clk;

   seg_xlate u_seg_xlate (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
      .cfg_present(cfg_present), .cfg_store_ok(cfg_store_ok),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
   );

   function automatic logic [17:0] expect_x(input logic [15:0] a, input logic w);
      int s;
      logic [15:0] o;
      logic [1:0] f;
      s = int'(a[15:14]);
      o = {2'b00, a[13:0]};
      if (!m_pres[s])              f = 2'b01;
      else if (o >= m_lim[s])      f = 2'b10;
      else if (w && !m_stok[s])    f = 2'b11;
      else                         f = 2'b00;
      return {f, (f == 2'b00) ? 16'(m_base[s] + o) : 16'h0};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic prog(input int idx, input logic [15:0] b, input logic [15:0] l,
                       input logic p, input logic s);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_base = b; cfg_limit = l;
      cfg_present = p; cfg_store_ok = s;
      @(negedge clk);
      cfg_we = 1'b0;
      m_base[idx] = b; m_lim[idx] = l; m_pres[idx] = p; m_stok[idx] = s;
   endtask

   task automatic xlate(input logic [15:0] a, input logic w, input string req);
      logic [17:0] e;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w;
      e = expect_x(a, w);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1 && {rsp_fault, rsp_paddr} == e, req,
            {13'h0, rsp_valid, rsp_fault, rsp_paddr}, {13'h0, 1'b1, e});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 4; i++) begin
         m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 1'b0; m_stok[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      check(rsp_valid == 1'b0, "R9 rsp_valid after reset", 32'(rsp_valid), 32'h0);
      for (int s = 0; s < 4; s++) xlate(16'(s << 14), 1'b0, "R9 descriptor absent after reset");

      // R1 R2: worked examples
      prog(0, 16'h4000, 16'h0800, 1'b1, 1'b0);
      prog(1, 16'h4800, 16'h1400, 1'b1, 1'b1);
      prog(2, 16'hF000, 16'h1000, 1'b0, 1'b1);
      prog(3, 16'hFF00, 16'h3000, 1'b1, 1'b1);
      xlate(16'h0240, 1'b0, "R2 seg0 translate");
      xlate(16'h4050, 1'b0, "R1 seg1 select");
      xlate(16'h4050, 1'b1, "R5 store to writable");
      // R3: limit boundaries
      xlate(16'h07FF, 1'b0, "R3 last in-range offset");
      xlate(16'h0800, 1'b0, "R3 offset equal to limit");
      // R2: wrap
      xlate(16'hC200, 1'b0, "R2 wrap modulo 2^16");
      // R5
      xlate(16'h0100, 1'b1, "R5 store to read-only");
      xlate(16'h0100, 1'b0, "R5 load from read-only");
      // R4 R6 R10
      xlate(16'hBFFF, 1'b1, "R4 R6 absent beats limit and store");
      xlate(16'h0900, 1'b1, "R6 limit beats store permission");

      // R7: write and translate in the same cycle
      begin
         logic [17:0] e;
         @(negedge clk);
         cfg_we = 1'b1; cfg_sel = 2'd0; cfg_base = 16'h1000; cfg_limit = 16'h0800;
         cfg_present = 1'b1; cfg_store_ok = 1'b0;
         req_valid = 1'b1; req_addr = 16'h0010; req_write = 1'b0;
         e = expect_x(16'h0010, 1'b0);
         @(negedge clk);
         cfg_we = 1'b0; req_valid = 1'b0;
         check({rsp_fault, rsp_paddr} == e, "R7 same-cycle uses old descriptor",
               32'({rsp_fault, rsp_paddr}), 32'(e));
         m_base[0] = 16'h1000;
      end
      xlate(16'h0010, 1'b0, "R7 new descriptor after edge");

      // R8: backpressure
      begin
         logic [15:0] held;
         @(negedge clk);
         rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 16'h4060; req_write = 1'b0;
         @(negedge clk);
         held = rsp_paddr;
         check(rsp_valid && !req_ready, "R8 ready low while stalled",
               {30'h0, rsp_valid, req_ready}, 32'h2);
         req_addr = 16'h4070;
         repeat (2) @(negedge clk);
         check(rsp_valid && rsp_paddr == held && held == 16'h4860, "R8 response held",
               32'(rsp_paddr), 32'h4860);
         rsp_ready = 1'b1; req_valid = 1'b0;
         @(negedge clk);
         check(!rsp_valid, "R8 response drains", 32'(rsp_valid), 32'h0);
      end

      // random mix
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 8) == 0)
            prog(int'($urandom % 4), 16'($urandom), 16'($urandom % 16'h4400),
                 1'($urandom % 4 != 0), 1'($urandom));
         else
            xlate(16'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 random");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule